// File: doc/BRIEF.md
# Nibble-Bus Port Expander

This block adds four 4-bit ports behind a shared 4-bit bidirectional bus. A master controls it with an active-low select line and a single strobe line, PROG. While PROG is high the master places a command nibble on the bus, then pulls PROG low. The high-to-low transition captures the command. For a write, the master then puts the data nibble on the bus and returns PROG high, and the rising transition latches that nibble onto the chosen port's outputs. For a read, the block drives the chosen port's input levels onto the bus for as long as PROG stays low.

The bus is modelled as separate input, output and output-enable signals. Select, PROG and the bus input are resynchronised to the system clock through a two-flop chain. All three are delayed by the same amount, so each edge is paired with the bus value that was present when it occurred. Several expanders can share one bus because a deselected block never drives it.

Top module: `nib_port_expander`

## Requirements
- R1: After reset, every port output nibble is 0 and `bus_oe_o` is low. No command is pending.
- R2: A command nibble whose bits [3:2] are 01 is a write. The nibble on the bus at the next PROG rising transition is latched onto the port selected by bits [1:0].
- R3: A command whose bits [3:2] are 00 is a read. While PROG stays low, `bus_oe_o` is high and `bus_o` carries the selected port's input nibble.
- R4: `bus_oe_o` is high only while select is low, a read command is pending and PROG is low. It is low from the cycle after the PROG rising transition is detected.
- R5: While select is high, the block ignores PROG and the bus. No port changes, `bus_oe_o` stays low, and deselecting abandons any pending command.
- R6: Commands with bits [3:2] equal to 10 or 11 change no port and never drive the bus.
- R7: Port index i (0..3) stands for port 4+i and occupies `port_out_o[4*i+3:4*i]` and `port_in_i[4*i+3:4*i]`. A write changes only that nibble.
- R8: Inputs pass a two-flop synchronizer. A write appears on `port_out_o` at the third rising clock edge after the PROG pin goes high, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n_i | input | 1 | Active-low select |
| prog_i | input | 1 | Command/data strobe |
| bus_i | input | 4 | Nibble bus, master to block |
| bus_o | output | 4 | Nibble bus, block to master (0 when not driving) |
| bus_oe_o | output | 1 | Block drives the bus |
| port_in_i | input | 16 | Input levels of ports 4..7, index i at [4i+3:4i] |
| port_out_o | output | 16 | Output latches of ports 4..7, index i at [4i+3:4i] |

## Verification
Writes go to every port with distinct data, and each one is followed by checks that no other port nibble moved, which separates correct index decoding from aliasing. Reads use a different input pattern on each port, so a wrong port selection or a wrong nibble order shows up on `bus_o`. Writes with select held high and commands with the two unused codes carry data that would be visible if latched, which separates ignoring from committing. A clock-by-clock count after a PROG rise pins the synchronizer latency to exactly three edges.

// File: rtl/nibx_pkg.sv
package nibx_pkg;
  localparam int NIB     = 4;
  localparam int NPORT   = 4;
  localparam int SELW    = $clog2(NPORT);
  localparam int PORTS_W = NIB * NPORT;

  typedef enum logic [1:0] {
    OP_RD  = 2'b00,
    OP_WR  = 2'b01,
    OP_NA2 = 2'b10,
    OP_NA3 = 2'b11
  } op_e;

  typedef struct packed {
    op_e             op;
    logic [SELW-1:0] sel;
  } cmd_t;

  function automatic cmd_t cmd_decode(input logic [NIB-1:0] n);
    cmd_t c;
    c.op  = op_e'(n[NIB-1:SELW]);
    c.sel = n[SELW-1:0];
    return c;
  endfunction

  function automatic logic [NIB-1:0] port_pick(input logic [PORTS_W-1:0] v,
                                                input logic [SELW-1:0] s);
    return v[s*NIB +: NIB];
  endfunction

  function automatic logic is_fall(input logic prev, input logic cur);
    return prev & ~cur;
  endfunction

  function automatic logic is_rise(input logic prev, input logic cur);
    return ~prev & cur;
  endfunction
endpackage

// File: rtl/nibx_sync.sv
module nibx_sync #(
  parameter int         W      = 1,
  parameter int         STAGES = 2,
  parameter logic [W-1:0] RST  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/nibx_seq.sv
module nibx_seq
  import nibx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_s,
  input  logic            pg_s,
  input  logic [NIB-1:0]  bus_s,
  output logic            fall_ev,
  output logic            rise_ev,
  output logic            pend,
  output cmd_t            cmd,
  output logic            wr_en,
  output logic [NIB-1:0]  wr_data,
  output logic            rd_drive
);
  logic pg_d;

  assign fall_ev = is_fall(pg_d, pg_s) & ~cs_s;
  assign rise_ev = is_rise(pg_d, pg_s);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pg_d <= 1'b1;
      pend <= 1'b0;
      cmd  <= '0;
    end else begin
      pg_d <= pg_s;
      if (fall_ev) begin
        pend <= 1'b1;
        cmd  <= cmd_decode(bus_s);
      end else if (rise_ev || cs_s) begin
        pend <= 1'b0;
      end
    end
  end

  assign wr_en    = rise_ev & pend & ~cs_s & (cmd.op == OP_WR);
  assign wr_data  = bus_s;
  assign rd_drive = pend & ~cs_s & ~pg_s & (cmd.op == OP_RD);
endmodule

// File: rtl/nibx_bank.sv
module nibx_bank
  import nibx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SELW-1:0]    wr_sel,
  input  logic [NIB-1:0]     wr_data,
  output logic [PORTS_W-1:0] q
);
  for (genvar i = 0; i < NPORT; i++) begin : g_port
    logic [NIB-1:0] lat;
    always_ff @(posedge clk) begin
      if (!rst_n)                                 lat <= '0;
      else if (wr_en && (wr_sel == SELW'(i)))     lat <= wr_data;
    end
    assign q[i*NIB +: NIB] = lat;
  end
endmodule

// File: rtl/nib_port_expander.sv
module nib_port_expander
  import nibx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n_i,
  input  logic               prog_i,
  input  logic [NIB-1:0]     bus_i,
  output logic [NIB-1:0]     bus_o,
  output logic               bus_oe_o,
  input  logic [PORTS_W-1:0] port_in_i,
  output logic [PORTS_W-1:0] port_out_o
);
  localparam int SW = NIB + 2;

  logic [SW-1:0]  sync_q;
  logic           cs_s, pg_s;
  logic [NIB-1:0] bus_s;
  logic           fall_ev, rise_ev, pend, wr_en, rd_drive;
  logic [NIB-1:0] wr_data;
  cmd_t           cmd;
  logic [1:0]     cur_op;

  nibx_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST({2'b11, {NIB{1'b0}}})) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n_i, prog_i, bus_i}), .q(sync_q)
  );

  assign cs_s  = sync_q[SW-1];
  assign pg_s  = sync_q[SW-2];
  assign bus_s = sync_q[NIB-1:0];

  nibx_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .pg_s(pg_s), .bus_s(bus_s),
    .fall_ev(fall_ev), .rise_ev(rise_ev), .pend(pend), .cmd(cmd),
    .wr_en(wr_en), .wr_data(wr_data), .rd_drive(rd_drive)
  );

  nibx_bank u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(cmd.sel),
    .wr_data(wr_data), .q(port_out_o)
  );

  assign cur_op   = cmd.op;
  assign bus_oe_o = rd_drive;
  assign bus_o    = rd_drive ? port_pick(port_in_i, cmd.sel) : '0;
endmodule

// File: rtl/nibx_chk.sv
module nibx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fall_ev,
  input logic        rise_ev,
  input logic        cs_s,
  input logic        pend,
  input logic [1:0]  cur_op,
  input logic        bus_oe_o,
  input logic [15:0] port_out_o
);
  logic [15:0] prev_q;
  logic [3:0]  chg;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= port_out_o;
  end

  for (genvar i = 0; i < 4; i++) begin : g_chg
    assign chg[i] = prev_q[i*4 +: 4] != port_out_o[i*4 +: 4];
  end

  AST_OE_RISE_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe_o) |-> $past(fall_ev)); // R3
  AST_OE_DROP_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ev |=> !bus_oe_o); // R4
  AST_DESELECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> $stable(port_out_o)); // R5
  AST_NONWRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend && cur_op == 2'b01) |=> $stable(port_out_o)); // R6
  AST_ONE_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(chg) <= 1); // R7
endmodule

bind nib_port_expander nibx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fall_ev(fall_ev), .rise_ev(rise_ev),
  .cs_s(cs_s), .pend(pend), .cur_op(cur_op), .bus_oe_o(bus_oe_o),
  .port_out_o(port_out_o)
);

// File: tb/sim_nib_port_expander.sv
module sim_nib_port_expander;
  logic        clk = 0, rst_n = 0;
  logic        cs_n = 1, prog = 1;
  logic [3:0]  bus_i = 0;
  logic [3:0]  bus_o;
  logic        bus_oe;
  logic [15:0] pin = 16'h0, pout;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  nib_port_expander u0 (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .prog_i(prog), .bus_i(bus_i),
    .bus_o(bus_o), .bus_oe_o(bus_oe), .port_in_i(pin), .port_out_o(pout)
  );

  // behavioural reference: delay line of pin samples plus command state
  logic [5:0]  hq[$];
  int          m_pend, m_op, m_sel;
  logic [15:0] m_port;
  logic        e_oe;
  logic [3:0]  e_bus;

  initial begin
    hq = '{6'h30, 6'h30, 6'h30};
    m_pend = 0; m_op = 0; m_sel = 0; m_port = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      hq = '{6'h30, 6'h30, 6'h30};
      m_pend = 0; m_op = 0; m_sel = 0; m_port = 0;
    end else begin
      logic c, p, pd;
      logic [3:0] b;
      c = hq[1][5]; p = hq[1][4]; pd = hq[2][4]; b = hq[1][3:0];
      if (pd && !p && !c) begin
        m_pend = 1; m_op = int'(b[3:2]); m_sel = int'(b[1:0]);
      end else if (!pd && p) begin
        if (m_pend == 1 && !c && m_op == 1) m_port[m_sel*4 +: 4] = b;
        m_pend = 0;
      end else if (c) begin
        m_pend = 0;
      end
      hq.push_front({cs_n, prog, bus_i});
      void'(hq.pop_back());
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      e_oe  = (m_pend == 1) && (m_op == 0) && !hq[1][4] && !hq[1][5];
      e_bus = e_oe ? pin[m_sel*4 +: 4] : 4'h0;
      chk(cur_req, "port_out model", pout, m_port);
      chk(cur_req, "bus_oe model", bus_oe, e_oe);
      chk(cur_req, "bus_o model", bus_o, e_bus);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(logic sel_n, logic [3:0] cmd, logic [3:0] data);
    @(negedge clk); cs_n = sel_n; bus_i = cmd; prog = 1; idle(4);
    prog = 0; idle(5);
    bus_i = data; idle(4);
    prog = 1; idle(5);
    cs_n = 1; bus_i = 0; idle(3);
  endtask

  task automatic rd(int idx, logic [3:0] exp);
    @(negedge clk); cs_n = 0; bus_i = 4'(idx); prog = 1; idle(4);
    prog = 0; idle(5);
    bus_i = 0;
    chk("R3", "read drive enable", bus_oe, 1'b1);
    chk("R3", "read nibble", bus_o, exp);
    prog = 1; idle(5);
    chk("R4", "enable released after rise", bus_oe, 1'b0);
    cs_n = 1; idle(3);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual expired expected finish");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle(4);
    chk("R1", "reset port_out", pout, 16'h0);
    chk("R1", "reset bus_oe", bus_oe, 1'b0);
    rst_n = 1; idle(3);
    chk("R1", "after reset port_out", pout, 16'h0);

    cur_req = "R2";
    xfer(0, 4'b0100, 4'hA);
    chk("R2", "write port4", pout, 16'h000A);
    cur_req = "R7";
    xfer(0, 4'b0110, 4'h5);
    chk("R7", "write port6 only", pout, 16'h050A);
    xfer(0, 4'b0111, 4'hC);
    xfer(0, 4'b0101, 4'h3);
    chk("R7", "all four ports", pout, 16'hC53A);
    xfer(0, 4'b0100, 4'hF);
    chk("R7", "rewrite port4", pout, 16'hC53F);

    cur_req = "R3";
    pin = 16'h9E61;
    rd(0, 4'h1); rd(1, 4'h6); rd(2, 4'hE); rd(3, 4'h9);
    chk("R3", "read leaves ports", pout, 16'hC53F);

    cur_req = "R5";
    xfer(1, 4'b0101, 4'h0);
    chk("R5", "deselected write ignored", pout, 16'hC53F);
    chk("R5", "deselected no drive", bus_oe, 1'b0);

    cur_req = "R6";
    xfer(0, 4'b1001, 4'h7);
    xfer(0, 4'b1110, 4'h8);
    chk("R6", "unused codes ignored", pout, 16'hC53F);

    cur_req = "R8";
    @(negedge clk); cs_n = 0; bus_i = 4'b0110; idle(4);
    prog = 0; idle(5);
    bus_i = 4'h2; idle(4);
    prog = 1;
    @(posedge clk); @(posedge clk); #2;
    chk("R8", "not yet after two edges", pout, 16'hC53F);
    @(posedge clk); #2;
    chk("R8", "visible at third edge", pout, 16'hC23F);
    idle(4); cs_n = 1; idle(3);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule